// File: doc/BRIEF.md
# Power-down wakeup monitor

This block runs the power-down phase of a three-wire serial converter interface. Once the command decoder has recognised one of the two power-down opcodes, the monitor counts serial clock edges within the frame. On the fifth rising edge it enters power-down. It then drives the bidirectional data line to an idle level chosen by the opcode and raises a power-down status.

While powered down, the monitor watches every channel input that is set to digital and has wakeup enabled. The first change on any such channel flips the level on the data line, which tells the host to end the phase. The flipped level then holds, and later channel activity is ignored. When the host raises the frame strobe, the status and the wake latch clear and the data line returns to high impedance.

All detection runs on the system clock. The serial clock may stop once power-down has been entered. The frame strobe, the serial clock and the channel levels are all passed through synchronizer stages before use.

Top module: `pdw_monitor`

## Requirements
- R1: After reset, pd_active_o, dio_oe_o and dio_o are 0.
- R2: Power-down is entered only if pd_cmd_i is high at the fifth rising edge of sclk_i counted from the fall of start_i. With pd_cmd_i low, five or more sclk_i edges leave pd_active_o at 0.
- R3: In power-down, dio_oe_o is 1. Before any wake, dio_o equals the latched pd_mode_i: mode 0 for opcode 000 gives dio_o = 0, and mode 1 for opcode 111 gives dio_o = 1.
- R4: A level change on channel c wakes the block only when attr_i[c] = 0 (digital) and wake_en_i[c] = 1. A wake sets dio_o to the inverse of the mode level.
- R5: After a wake, dio_o holds the inverted level, and further channel changes have no effect until start_i rises.
- R6: A channel change that occurs before the fifth sclk_i rising edge is not counted as a wake.
- R7: A rise of start_i clears pd_active_o, dio_oe_o and the wake latch.
- R8: A wake is detected with no sclk_i activity. dio_o changes on the third system-clock edge after the channel input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame strobe from the host, low during a frame |
| sclk_i | input | 1 | Serial clock from the host |
| pd_cmd_i | input | 1 | Decoder reports a power-down opcode in the current frame |
| pd_mode_i | input | 1 | Decoded mode: 0 for opcode 000, 1 for opcode 111 |
| ch_i | input | NUM_CH | Channel input levels |
| attr_i | input | NUM_CH | Channel attribute, 1 = analog, 0 = digital |
| wake_en_i | input | NUM_CH | Wakeup enable per channel |
| dio_o | output | 1 | Value driven on the data line |
| dio_oe_o | output | 1 | Data line output enable |
| pd_active_o | output | 1 | Power-down status |

## Verification
Each external input passes two synchronizer flops and then one state register. Entry into power-down, a wake and the clear on start_i therefore all appear on the third system-clock edge after the input changes. The bench drives inputs and samples outputs on falling clock edges. The wake latency is checked exactly: the output is sampled after two edges, where the old value is expected, and after three, where the new value is expected. The other checks are made after a settle of several edges. The sweep covers every channel, every attribute and enable pairing, and both modes.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int unsigned NUM_CH_DEF     = 8;
  localparam int unsigned ENTRY_EDGE_DEF = 5;
  localparam int unsigned SYNC_DEF       = 2;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_V;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pdw_frame.sv
module pdw_frame #(
  parameter int unsigned ENTRY_EDGE = 5,
  localparam int unsigned CW = $clog2(ENTRY_EDGE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_s_i,
  input  logic sclk_s_i,
  input  logic pd_cmd_i,
  output logic enter_o
);
  logic          sclk_d_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = sclk_s_i & ~sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      if (start_s_i)
        cnt_q <= '0;
      else if (rise && cnt_q != CW'(ENTRY_EDGE))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign enter_o = rise && !start_s_i && pd_cmd_i && (cnt_q == CW'(ENTRY_EDGE - 1));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(ENTRY_EDGE));
  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s_i |=> (cnt_q == '0));
endmodule

// File: rtl/pdw_wake.sv
module pdw_wake #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_s_i,
  input  logic              enter_i,
  input  logic              mode_i,
  input  logic [NUM_CH-1:0] ch_s_i,
  input  logic [NUM_CH-1:0] attr_i,
  input  logic [NUM_CH-1:0] wake_en_i,
  output logic              pd_o,
  output logic              mode_o,
  output logic              woken_o
);
  logic [NUM_CH-1:0] ch_d_q;
  logic [NUM_CH-1:0] trans;
  logic              pd_q, mode_q, woken_q;

  assign trans = (ch_s_i ^ ch_d_q) & ~attr_i & wake_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_d_q  <= '0;
      pd_q    <= 1'b0;
      mode_q  <= 1'b0;
      woken_q <= 1'b0;
    end else begin
      ch_d_q <= ch_s_i;
      if (start_s_i) begin
        pd_q    <= 1'b0;
        woken_q <= 1'b0;
      end else if (enter_i && !pd_q) begin
        pd_q   <= 1'b1;
        mode_q <= mode_i;
      end else if (pd_q && !woken_q && |trans) begin
        woken_q <= 1'b1;
      end
    end
  end

  assign pd_o    = pd_q;
  assign mode_o  = mode_q;
  assign woken_o = woken_q;

  // R5
  woken_in_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    woken_q |-> pd_q);
  // R4
  wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(woken_q) |-> $past(|trans));
  // R2
  entry_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(enter_i));
  // R5
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (woken_q && !start_s_i) |=> (woken_q && $stable(mode_q)));
endmodule

// File: rtl/pdw_monitor.sv
module pdw_monitor
  import pdw_pkg::*;
#(
  parameter int unsigned NUM_CH     = NUM_CH_DEF,
  parameter int unsigned ENTRY_EDGE = ENTRY_EDGE_DEF,
  parameter int unsigned SYNC       = SYNC_DEF,
  localparam int unsigned SW = NUM_CH + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sclk_i,
  input  logic              pd_cmd_i,
  input  logic              pd_mode_i,
  input  logic [NUM_CH-1:0] ch_i,
  input  logic [NUM_CH-1:0] attr_i,
  input  logic [NUM_CH-1:0] wake_en_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              pd_active_o
);
  logic [SW-1:0]     sync_q;
  logic              start_s, sclk_s, enter;
  logic [NUM_CH-1:0] ch_s;
  logic              pd, mode, woken;

  pdw_sync #(.W(SW), .STAGES(SYNC), .RST_V({1'b1, {(SW-1){1'b0}}})) u_sync (
    .clk_i, .rst_ni,
    .d_i({start_i, sclk_i, ch_i}),
    .q_o(sync_q)
  );

  assign start_s = sync_q[SW-1];
  assign sclk_s  = sync_q[SW-2];
  assign ch_s    = sync_q[NUM_CH-1:0];

  pdw_frame #(.ENTRY_EDGE(ENTRY_EDGE)) u_frame (
    .clk_i, .rst_ni,
    .start_s_i(start_s),
    .sclk_s_i(sclk_s),
    .pd_cmd_i,
    .enter_o(enter)
  );

  pdw_wake #(.NUM_CH(NUM_CH)) u_wake (
    .clk_i, .rst_ni,
    .start_s_i(start_s),
    .enter_i(enter),
    .mode_i(pd_mode_i),
    .ch_s_i(ch_s),
    .attr_i, .wake_en_i,
    .pd_o(pd),
    .mode_o(mode),
    .woken_o(woken)
  );

  assign pd_active_o = pd;
  assign dio_oe_o    = pd;
  assign dio_o       = pd & (mode ^ woken);

  // R7
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s |=> !pd_active_o);
  // R3
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dio_oe_o |-> !dio_o);
endmodule

// File: tb/pdw_monitor_tb.sv
module pdw_monitor_tb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b1, sclk = 1'b0, pd_cmd = 1'b0, pd_mode = 1'b0;
  logic [N-1:0] ch = '0, attr = '0, wen = '0;
  logic dio, dio_oe, pd_act;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdw_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sclk_i(sclk),
    .pd_cmd_i(pd_cmd), .pd_mode_i(pd_mode), .ch_i(ch), .attr_i(attr),
    .wake_en_i(wen), .dio_o(dio), .dio_oe_o(dio_oe), .pd_active_o(pd_act)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (pd,oe,dio)", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; step(4); sclk = 1'b0; step(4);
    end
  endtask

  task automatic begin_frame(input logic cmd, input logic m);
    start = 1'b1; step(5);
    start = 1'b0; pd_cmd = cmd; pd_mode = m; step(4);
  endtask

  initial begin
    step(3);
    chk("R1", {pd_act, dio_oe, dio}, 3'b000);
    rst_n = 1'b1; step(4);
    chk("R1", {pd_act, dio_oe, dio}, 3'b000);

    // R2: no power-down opcode, no entry
    begin_frame(1'b0, 1'b0); pulses(7);
    chk("R2", {pd_act, dio_oe, dio}, 3'b000);
    // R2: only four edges
    begin_frame(1'b1, 1'b1); pulses(4);
    chk("R2", {pd_act, dio_oe, dio}, 3'b000);
    pulses(1);
    chk("R2", {pd_act, dio_oe, dio}, 3'b111);

    // R6: change before fifth edge ignored
    for (int m = 0; m < 2; m++) begin
      attr = '0; wen = '1;
      begin_frame(1'b1, m[0]); pulses(4);
      ch[3] = ~ch[3]; step(2);
      pulses(1);
      chk("R6", {pd_act, dio_oe, dio}, {2'b11, m[0]});
    end

    // R3 R4 R5 R7 R8: sweep mode, channel, attribute/enable
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < N; c++)
        for (int k = 0; k < 4; k++) begin
          logic q;
          attr = '1; wen = '0;
          attr[c] = k[0]; wen[c] = k[1];
          q = ~k[0] & k[1];
          begin_frame(1'b1, m[0]); pulses(5);
          pd_cmd = 1'b0;
          chk("R3", {pd_act, dio_oe, dio}, {2'b11, m[0]});
          ch[c] = ~ch[c]; step(2);
          chk("R8", {pd_act, dio_oe, dio}, {2'b11, m[0]});
          step(1);
          chk("R4", {pd_act, dio_oe, dio}, {2'b11, m[0] ^ q});
          ch[c] = ~ch[c]; step(6);
          if (q) chk("R5", {pd_act, dio_oe, dio}, {2'b11, ~m[0]});
          else   chk("R4", {pd_act, dio_oe, dio}, {2'b11, m[0]});
          start = 1'b1; step(5);
          chk("R7", {pd_act, dio_oe, dio}, 3'b000);
        end

    // R5: multiple qualifying channels, second change ignored
    attr = '0; wen = '1;
    begin_frame(1'b1, 1'b0); pulses(5);
    ch[0] = ~ch[0]; step(5);
    ch[5] = ~ch[5]; step(5);
    chk("R5", {pd_act, dio_oe, dio}, 3'b111);
    start = 1'b1; step(5);
    chk("R7", {pd_act, dio_oe, dio}, 3'b000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule